// File: doc/BRIEF.md
# Hybrid Priority Round-Robin Arbiter

This block decides which of `NUM_CH` requesting channels is granted the next turn at a shared transfer engine. A 2-bit run-time mode removes a run of the lowest-numbered channels from the rotation and serves them by strict priority. Every other channel shares a round-robin rotation. The mode sets the size of that priority group: none, `GRP_A`, `GRP_B` or `GRP_C` channels, which by default is 0, 2, 4 or 16.

The grant is combinational from the request vector, the mode and a stored rotation pointer. The consumer raises `accept` in a cycle where it takes up the grant. Only an accepted grant to a round-robin channel moves the pointer, and it moves to the channel just after the granted one. Channel 1 is bit 0 of every vector, and `grant_idx` is the zero-based bit position.

Top module: `hpr_arbiter`

## Requirements
- R1: Mode 2'b00 has an empty priority group, and every requesting channel takes part in the rotation.
- R2: Modes 2'b01, 2'b10 and 2'b11 put bits 0..GRP_A-1, 0..GRP_B-1 and 0..GRP_C-1 respectively in the priority group. The defaults are 2, 4 and 16.
- R3: Among requesting priority-group channels, the lowest bit index is granted.
- R4: A request from any priority-group channel wins over every round-robin request.
- R5: The round-robin search starts at the effective pointer, runs upward, wraps past bit NUM_CH-1 and skips priority-group bits.
- R6: An accepted grant to a round-robin channel at bit k moves the pointer to k+1. If k is NUM_CH-1, the pointer moves to the first round-robin bit.
- R7: A cycle without an accepted round-robin grant leaves the effective pointer unchanged. This includes an accepted priority grant.
- R8: With no request, `grant_vld` is 0, `grant` is all zeros and `grant_idx` is 0.
- R9: With any request, `grant_vld` is 1, `grant` is one-hot on a requesting bit, and `grant_idx` is the position of that bit.
- R10: After reset the pointer is at bit 0, so the first round-robin grant in mode 2'b00 goes to the lowest requesting bit.
- R11: A mode change applies to the very next decision. A pointer that falls inside the new priority group acts as the first round-robin bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_CH | Per-channel request, bit 0 is channel 1 |
| mode | input | 2 | Priority-group size select |
| accept | input | 1 | The current grant is taken up this cycle |
| grant | output | NUM_CH | One-hot grant |
| grant_idx | output | $clog2(NUM_CH) | Bit index of the granted channel |
| grant_vld | output | 1 | A grant is present |

## Verification
The bench builds the arbiter with `NUM_CH` = 20 and the default group sizes 2, 4 and 16. With these values, mode 2'b11 leaves a rotation of only four channels. That small rotation makes wrap-around from the top bit and pointer clamping after a mode change happen often. Directed sequences cover each mode's group boundary, and thousands of pseudo-random request, mode and accept patterns run against a bench-side arithmetic model of the pointer.

// File: rtl/hpr_pkg.sv
package hpr_pkg;

   // Size of the strict-priority group for each mode code.
   function automatic int unsigned grp_size(input logic [1:0] m,
                                            input int unsigned ga,
                                            input int unsigned gb,
                                            input int unsigned gc);
      case (m)
         2'b00:   grp_size = 0;
         2'b01:   grp_size = ga;
         2'b10:   grp_size = gb;
         default: grp_size = gc;
      endcase
   endfunction

endpackage

// File: rtl/hpr_lowpick.sv
module hpr_lowpick #(
   parameter int W     = 8,
   parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/hpr_rr_pick.sv
module hpr_rr_pick #(
   parameter int NUM_CH = 40,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] cand,
   input  logic [IDX_W-1:0]  start,
   output logic              found,
   output logic [IDX_W-1:0]  idx
);
   logic [NUM_CH-1:0] upper_mask;
   logic [IDX_W-1:0]  up_idx, all_idx;
   logic              up_found, all_found;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_up
      assign upper_mask[i] = (IDX_W'(i) >= start);
   end

   hpr_lowpick #(.W(NUM_CH), .IDX_W(IDX_W)) u_up (
      .vec(cand & upper_mask), .found(up_found), .idx(up_idx));
   hpr_lowpick #(.W(NUM_CH), .IDX_W(IDX_W)) u_all (
      .vec(cand), .found(all_found), .idx(all_idx));

   assign found = all_found;
   assign idx   = up_found ? up_idx : all_idx;
endmodule

// File: rtl/hpr_ptr_reg.sv
module hpr_ptr_reg #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] d,
   output logic [IDX_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/hpr_arbiter.sv
module hpr_arbiter #(
   parameter int NUM_CH = 40,
   parameter int GRP_A  = 2,
   parameter int GRP_B  = 4,
   parameter int GRP_C  = 16,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic [1:0]        mode,
   input  logic              accept,
   output logic [NUM_CH-1:0] grant,
   output logic [IDX_W-1:0]  grant_idx,
   output logic              grant_vld
);
   if (NUM_CH < 17) begin : g_bad_n
      $error("hpr_arbiter: NUM_CH must be at least 17");
   end
   if (!(GRP_A > 0 && GRP_A <= GRP_B && GRP_B <= GRP_C && GRP_C < NUM_CH)) begin : g_bad_grp
      $error("hpr_arbiter: group sizes must ascend and stay below NUM_CH");
   end

   logic [IDX_W-1:0]  psize, ptr_q, ptr_d, eff_ptr, pidx, ridx;
   logic [NUM_CH-1:0] pmask;
   logic              pfound, rfound;

   assign psize = IDX_W'(hpr_pkg::grp_size(mode, GRP_A, GRP_B, GRP_C));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_pmask
      assign pmask[i] = (IDX_W'(i) < psize);
   end

   // Pointer inside the priority group behaves as the first rotation bit.
   assign eff_ptr = (ptr_q < psize) ? psize : ptr_q;

   hpr_lowpick #(.W(NUM_CH), .IDX_W(IDX_W)) u_prio (
      .vec(req & pmask), .found(pfound), .idx(pidx));

   hpr_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
      .cand(req & ~pmask), .start(eff_ptr), .found(rfound), .idx(ridx));

   assign grant_vld = pfound | rfound;
   assign grant_idx = pfound ? pidx : ridx;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_grant
      assign grant[i] = grant_vld && (grant_idx == IDX_W'(i));
   end

   always_comb begin
      ptr_d = eff_ptr;
      if (grant_vld && accept && !pfound) begin
         if (ridx == IDX_W'(NUM_CH - 1)) ptr_d = psize;
         else                            ptr_d = ridx + 1'b1;
      end
   end

   hpr_ptr_reg #(.IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .d(ptr_d), .q(ptr_q));

   // R8
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> (!grant_vld && grant == '0));
   // R9
   onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (grant_vld && $onehot(grant) && (grant & ~req) == '0));
   // R4
   prio_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req & pmask) != '0) |-> (grant_idx < psize));
   // R3
   prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld && grant_idx < psize) |->
         ((req & ((NUM_CH'(1) << grant_idx) - NUM_CH'(1))) == '0));
   // R6
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld && accept && grant_idx >= psize && grant_idx != IDX_W'(NUM_CH - 1))
         |=> (ptr_q == $past(grant_idx) + 1'b1));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept || !grant_vld || grant_idx < psize) |=> (ptr_q == $past(eff_ptr)));
endmodule

// File: tb/sim_hpr_arbiter.sv
module sim_hpr_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int N = 20;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [1:0]    mode = 2'b00;
   logic          accept = 1'b0;
   logic [N-1:0]  grant;
   logic [IW-1:0] grant_idx;
   logic          grant_vld;

   int checks = 0;
   int failures = 0;
   int mptr = 0;
   bit done = 0;
   logic [31:0] lfsr = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   hpr_arbiter #(.NUM_CH(N)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .accept(accept),
      .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld));

   function automatic int psz(input logic [1:0] m);
      case (m)
         2'b00: return 0;
         2'b01: return 2;
         2'b10: return 4;
         default: return 16;
      endcase
   endfunction

   function automatic logic [31:0] rnd(input logic [31:0] s);
      logic [31:0] x = s;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      return x;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] r, input logic [1:0] m, input logic a, input string tag);
      int ps, eff, e;
      bit isp;
      logic [N-1:0] ev;
      @(negedge clk);
      req = r; mode = m; accept = a;
      #1;
      ps = psz(m);
      eff = (mptr < ps) ? ps : mptr;
      e = -1;
      for (int i = 0; i < ps; i++) if (r[i] && e < 0) e = i;
      isp = (e >= 0);
      if (!isp)
         for (int k = 0; k < N; k++) begin
            int c = (eff + k) % N;
            if (c >= ps && r[c] && e < 0) e = c;
         end
      ev = (e >= 0) ? (N'(1) << e) : '0;
      chk(grant_vld == (e >= 0) && grant == ev && grant_idx == IW'((e < 0) ? 0 : e),
          tag, {23'd0, grant_vld, grant_idx, 14'd0, grant},
          {23'd0, e >= 0, IW'((e < 0) ? 0 : e), 14'd0, ev});
      if (a && e >= 0 && !isp) mptr = (e == N - 1) ? ps : e + 1;
      else                     mptr = eff;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mptr = 0;
      // R8 idle after reset
      step('0, 2'b00, 1'b0, "R8");
      // R10 first rotation grant goes to bit 0
      step('1, 2'b00, 1'b1, "R10");
      // R1 / R6 full rotation in mode 00
      for (int i = 0; i < N + 3; i++) step('1, 2'b00, 1'b1, "R1_R6");
      // R5 wrap with sparse requests
      step(N'(1) << (N - 1), 2'b01, 1'b1, "R6");
      step((N'(1) << 3) | (N'(1) << 9), 2'b01, 1'b1, "R5");
      step((N'(1) << 3) | (N'(1) << 9), 2'b01, 1'b1, "R5");
      step((N'(1) << 3) | (N'(1) << 9), 2'b01, 1'b1, "R5");
      // R2 group boundaries
      step((N'(1) << 1) | (N'(1) << 5), 2'b01, 1'b0, "R2");
      step((N'(1) << 2) | (N'(1) << 5), 2'b01, 1'b0, "R2");
      step((N'(1) << 3) | (N'(1) << 10), 2'b10, 1'b0, "R2");
      step((N'(1) << 4) | (N'(1) << 10), 2'b10, 1'b0, "R2");
      step((N'(1) << 15) | (N'(1) << 17), 2'b11, 1'b0, "R2");
      step((N'(1) << 16) | (N'(1) << 17), 2'b11, 1'b0, "R2");
      // R3 / R4
      step((N'(1) << 7) | (N'(1) << 12) | (N'(1) << 18), 2'b11, 1'b1, "R3");
      step((N'(1) << 1) | (N'(1) << 0) | '1, 2'b10, 1'b1, "R4");
      // R7 priority accepts keep the pointer
      for (int i = 0; i < 4; i++) step((N'(1) << 2) | (N'(1) << 9), 2'b10, 1'b1, "R7");
      step((N'(1) << 6) | (N'(1) << 9) | (N'(1) << 12), 2'b10, 1'b0, "R7");
      step((N'(1) << 6) | (N'(1) << 9) | (N'(1) << 12), 2'b10, 1'b0, "R7");
      // R11 pointer clamp on mode change
      step('1, 2'b00, 1'b1, "R11");
      step('1, 2'b00, 1'b1, "R11");
      step(N'(20'hF_0000) | N'(20'h0_00F0), 2'b11, 1'b0, "R11");
      step(N'(20'h8_0020), 2'b10, 1'b0, "R11");
      step('0, 2'b11, 1'b1, "R8");
      // R9 sweep
      for (int i = 0; i < 8000; i++) begin
         logic [N-1:0] r;
         lfsr = rnd(lfsr);
         r = N'(lfsr);
         if (lfsr[31:29] == 3'b000) r = '0;
         else if (lfsr[28]) r = r & N'(20'hFFFF0);
         step(r, lfsr[21:20], lfsr[22] | lfsr[23], "R9");
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule